// File: doc/BRIEF.md
# Masked block-write memory array

This block is a synthesizable behavioural model of a four-bit-wide page-mode memory whose special feature is the block write. One column cycle can place a stored four-bit colour value into up to four neighbouring columns of the open row. Two independent gates control each write. The first is a per-column enable taken from the data lines. The second is a per-bit write mask held in a register. That mask can be reloaded, reused or bypassed each time a row is opened.

Events are single-cycle pulses sampled on the rising clock edge. A row-open pulse latches the row address from the multiplexed address bus and samples the two mask-mode inputs. Column-strobe pulses then perform reads, single-column writes or block writes inside that page until a row-close pulse ends it. A row-open pulse with the block-select input high is a colour-load cycle instead. It copies the data lines into the colour register and opens no page. The default geometry is 16 rows by 32 columns so that elaboration stays small. Setting both address-field parameters to 9 gives the full 262144-word array.

Top module: `mvr_blkwr_top`

## Requirements
- R1: After reset no page is open, the stored write mask is 4'b1111, the colour register is 4'b0000 and `rd_valid` is low.
- R2: A `row_open` pulse with `blk_sel` high loads `din` into the colour register and leaves the page closed, so column strobes that follow have no effect until a normal `row_open`.
- R3: A `row_open` pulse with `blk_sel` low latches `addr[ROW_BITS-1:0]` as the page row. All column cycles until `row_close` address that row. Column strobes while no page is open change nothing.
- R4: With `mask_keep`=0 and `mask_off`=0 at row open, `din` becomes the stored write mask and it gates every write in that page. Mask bit b = 1 enables data bit b.
- R5: With `mask_keep`=1 and `mask_off`=0 at row open, the previously stored mask gates the page and stays unchanged.
- R6: With `mask_off`=1 at row open, whatever the value of `mask_keep`, all four data bits are written and the stored mask is kept for later pages.
- R7: A column strobe with `wr_en`=1 and `blk_sel`=1 is a block write. Column address bits [COL_BITS-1:2] select a group of four columns and bits [1:0] are ignored. Column n of the group, the one whose low two bits equal n, receives the colour value only when `din[n]`=1.
- R8: In any write, data bits whose effective mask bit is 0 keep their previous value.
- R9: A column strobe with `wr_en`=1 and `blk_sel`=0 writes `din` into the single addressed column, gated by the effective mask of the page.
- R10: A column strobe with `wr_en`=0 in an open page presents the addressed word on `rd_data` with `rd_valid` high in the cycle after the strobe. At all other times `rd_valid` is low.
- R11: `mask_keep` and `mask_off` are sampled only at row open. Changes during the page do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_open | input | 1 | Row strobe pulse: opens a page, or loads the colour when `blk_sel` is high |
| row_close | input | 1 | Ends the open page |
| col_stb | input | 1 | Column strobe pulse |
| wr_en | input | 1 | Column cycle is a write (1) or a read (0) |
| blk_sel | input | 1 | Block function select |
| mask_keep | input | 1 | At row open: reuse the stored mask |
| mask_off | input | 1 | At row open: bypass the mask |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | 4 | Data, write mask, column mask or colour |
| rd_data | output | 4 | Read word |
| rd_valid | output | 1 | `rd_data` holds a fresh read result |

## Verification
The hardest state to reach is a page whose effective mask differs from what the mode inputs show in the same cycle. That happens in a reuse page that follows an earlier mask load, and in a bypass page that leaves a partial mask stored for later pages. Directed tasks first load a partial mask, then open reuse and bypass pages and move the mode inputs in the middle of a page. A random phase then mixes all three page kinds with random colours, groups and column masks. A bench-side model that follows the requirements predicts every stored word, and each word is read back through the port.

// File: rtl/mvr_pkg.sv
package mvr_pkg;
  localparam int unsigned WORD_W = 4;
  localparam int unsigned LANES  = 4;

  typedef enum logic [1:0] {
    MSK_LOAD = 2'd0,
    MSK_KEEP = 2'd1,
    MSK_OFF  = 2'd2
  } mask_mode_e;

  function automatic mask_mode_e decode_mode(input logic keep, input logic off);
    if (off)       return MSK_OFF;
    else if (keep) return MSK_KEEP;
    else           return MSK_LOAD;
  endfunction
endpackage

// File: rtl/mvr_ctrl.sv
module mvr_ctrl
  import mvr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 9,
  parameter int unsigned ROW_BITS = 4,
  parameter int unsigned COL_BITS = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                row_open,
  input  logic                row_close,
  input  logic                col_stb,
  input  logic                wr_en,
  input  logic                blk_sel,
  input  logic                mask_keep,
  input  logic                mask_off,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W-1:0]   din,
  output logic                page_q,
  output logic [ROW_BITS-1:0] row_q,
  output logic [COL_BITS-1:0] col,
  output logic [WORD_W-1:0]   eff_mask,
  output logic [WORD_W-1:0]   wmask_q,
  output logic [WORD_W-1:0]   colour_q,
  output mask_mode_e          mode_q,
  output logic                do_blk,
  output logic                do_wr,
  output logic                do_rd
);
  logic                page_d;
  logic [ROW_BITS-1:0] row_d;
  logic [WORD_W-1:0]   wmask_d, colour_d;
  mask_mode_e          mode_d, mode_in;
  logic                open_page, load_colour;

  assign mode_in     = decode_mode(mask_keep, mask_off);
  assign open_page   = row_open && !blk_sel;
  assign load_colour = row_open && blk_sel;
  assign col         = addr[COL_BITS-1:0];

  always_comb begin
    page_d   = page_q;
    row_d    = row_q;
    mode_d   = mode_q;
    wmask_d  = wmask_q;
    colour_d = colour_q;
    if (open_page) begin
      page_d = 1'b1;
      row_d  = addr[ROW_BITS-1:0];
      mode_d = mode_in;
      if (mode_in == MSK_LOAD) wmask_d = din;
    end else if (row_close) begin
      page_d = 1'b0;
    end
    if (load_colour) colour_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q   <= 1'b0;
      row_q    <= '0;
      mode_q   <= MSK_LOAD;
      wmask_q  <= '1;
      colour_q <= '0;
    end else begin
      page_q   <= page_d;
      row_q    <= row_d;
      mode_q   <= mode_d;
      wmask_q  <= wmask_d;
      colour_q <= colour_d;
    end
  end

  assign eff_mask = (mode_q == MSK_OFF) ? '1 : wmask_q;
  assign do_blk   = page_q && col_stb && wr_en && blk_sel;
  assign do_wr    = page_q && col_stb && wr_en && !blk_sel;
  assign do_rd    = page_q && col_stb && !wr_en;
endmodule

// File: rtl/mvr_lanes.sv
module mvr_lanes
  import mvr_pkg::*;
#(
  parameter int unsigned ROW_BITS = 4,
  parameter int unsigned COL_BITS = 5,
  localparam int unsigned IDX_W   = ROW_BITS + COL_BITS
) (
  input  logic                              do_blk,
  input  logic                              do_wr,
  input  logic [ROW_BITS-1:0]               row,
  input  logic [COL_BITS-1:0]               col,
  input  logic [WORD_W-1:0]                 din,
  input  logic [WORD_W-1:0]                 colour,
  input  logic [WORD_W-1:0]                 eff_mask,
  output logic [LANES-1:0][IDX_W-1:0]       lane_idx,
  output logic [LANES-1:0][WORD_W-1:0]      lane_be,
  output logic [LANES-1:0][WORD_W-1:0]      lane_data
);
  for (genvar n = 0; n < LANES; n++) begin : g_lane
    logic [COL_BITS-1:0] group_col;
    assign group_col = {col[COL_BITS-1:2], 2'(n)};
    if (n == 0) begin : g_first
      always_comb begin
        if (do_blk) begin
          lane_idx[n]  = {row, group_col};
          lane_be[n]   = din[n] ? eff_mask : '0;
          lane_data[n] = colour;
        end else begin
          lane_idx[n]  = {row, col};
          lane_be[n]   = do_wr ? eff_mask : '0;
          lane_data[n] = din;
        end
      end
    end else begin : g_rest
      always_comb begin
        lane_idx[n]  = {row, group_col};
        lane_be[n]   = (do_blk && din[n]) ? eff_mask : '0;
        lane_data[n] = colour;
      end
    end
  end
endmodule

// File: rtl/mvr_array.sv
module mvr_array
  import mvr_pkg::*;
#(
  parameter int unsigned IDX_W = 9,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [LANES-1:0][IDX_W-1:0]  lane_idx,
  input  logic [LANES-1:0][WORD_W-1:0] lane_be,
  input  logic [LANES-1:0][WORD_W-1:0] lane_data,
  input  logic                         rd_en,
  input  logic [IDX_W-1:0]             rd_idx,
  output logic [WORD_W-1:0]            rd_data,
  output logic                         rd_valid
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int n = 0; n < LANES; n++) begin
      if (lane_be[n] != '0)
        mem[lane_idx[n]] <= (mem[lane_idx[n]] & ~lane_be[n]) | (lane_data[n] & lane_be[n]);
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_en;
  end
endmodule

// File: rtl/mvr_blkwr_top.sv
module mvr_blkwr_top
  import mvr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 9,
  parameter int unsigned ROW_BITS = 4,
  parameter int unsigned COL_BITS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_open,
  input  logic              row_close,
  input  logic              col_stb,
  input  logic              wr_en,
  input  logic              blk_sel,
  input  logic              mask_keep,
  input  logic              mask_off,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        din,
  output logic [3:0]        rd_data,
  output logic              rd_valid
);
  localparam int unsigned IDX_W = ROW_BITS + COL_BITS;

  logic                         page_q, do_blk, do_wr, do_rd;
  logic [ROW_BITS-1:0]          row_q;
  logic [COL_BITS-1:0]          col;
  logic [WORD_W-1:0]            eff_mask, wmask_q, colour_q;
  mask_mode_e                   mode_q;
  logic [LANES-1:0][IDX_W-1:0]  lane_idx;
  logic [LANES-1:0][WORD_W-1:0] lane_be, lane_data;

  mvr_ctrl #(.ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .row_open(row_open), .row_close(row_close),
    .col_stb(col_stb), .wr_en(wr_en), .blk_sel(blk_sel),
    .mask_keep(mask_keep), .mask_off(mask_off), .addr(addr), .din(din),
    .page_q(page_q), .row_q(row_q), .col(col), .eff_mask(eff_mask),
    .wmask_q(wmask_q), .colour_q(colour_q), .mode_q(mode_q),
    .do_blk(do_blk), .do_wr(do_wr), .do_rd(do_rd)
  );

  mvr_lanes #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_lanes (
    .do_blk(do_blk), .do_wr(do_wr), .row(row_q), .col(col), .din(din),
    .colour(colour_q), .eff_mask(eff_mask),
    .lane_idx(lane_idx), .lane_be(lane_be), .lane_data(lane_data)
  );

  mvr_array #(.IDX_W(IDX_W)) u_array (
    .clk(clk), .rst_n(rst_n), .lane_idx(lane_idx), .lane_be(lane_be),
    .lane_data(lane_data), .rd_en(do_rd), .rd_idx({row_q, col}),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/mvr_blkwr_chk.sv
module mvr_blkwr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       row_open,
  input logic       col_stb,
  input logic       wr_en,
  input logic       blk_sel,
  input logic       mask_keep,
  input logic       mask_off,
  input logic       page_q,
  input logic [3:0] wmask_q,
  input logic [3:0] colour_q,
  input logic [1:0] mode_q,
  input logic [3:0] lane_be0,
  input logic       rd_valid
);
  a_r1_reset_state: assert property (@(posedge clk)
    $rose(rst_n) |-> (!page_q && wmask_q == 4'hF && colour_q == 4'h0 && !rd_valid));

  a_r10_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (page_q && col_stb && !wr_en) |=> rd_valid);

  a_r10_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(page_q && col_stb && !wr_en));

  a_r2_colour_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(colour_q) |-> $past(row_open && blk_sel));

  a_r3_page_opens_on_row: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(page_q) |-> $past(row_open && !blk_sel));

  a_r5_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wmask_q) |-> $past(row_open && !blk_sel && !mask_keep && !mask_off));

  a_r11_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(row_open && !blk_sel));

  a_r3_no_write_closed: assert property (@(posedge clk) disable iff (!rst_n)
    !page_q |-> (lane_be0 == 4'h0));
endmodule

bind mvr_blkwr_top mvr_blkwr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .row_open(row_open), .col_stb(col_stb),
  .wr_en(wr_en), .blk_sel(blk_sel), .mask_keep(mask_keep), .mask_off(mask_off),
  .page_q(page_q), .wmask_q(wmask_q), .colour_q(colour_q), .mode_q(mode_q),
  .lane_be0(lane_be[0]), .rd_valid(rd_valid)
);

// File: tb/mvr_blkwr_top_tb.sv
module mvr_blkwr_top_tb;
  localparam int ADDR_W = 9, ROW_BITS = 4, COL_BITS = 5;
  localparam int NROW = 1 << ROW_BITS, NCOL = 1 << COL_BITS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic row_open = 0, row_close = 0, col_stb = 0, wr_en = 0, blk_sel = 0;
  logic mask_keep = 0, mask_off = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [3:0] din = '0;
  logic [3:0] rd_data;
  logic rd_valid;

  int total = 0, bad = 0;
  logic [3:0] ref_mem [NROW*NCOL];
  logic [3:0] m_mask, m_colour;
  logic m_off;
  logic [ROW_BITS-1:0] m_row;
  bit done = 0;

  always #4 clk = ~clk;

  mvr_blkwr_top #(.ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_dut (
    .clk(clk), .rst_n(rst_n), .row_open(row_open), .row_close(row_close),
    .col_stb(col_stb), .wr_en(wr_en), .blk_sel(blk_sel), .mask_keep(mask_keep),
    .mask_off(mask_off), .addr(addr), .din(din), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] eff();
    return m_off ? 4'hF : m_mask;
  endfunction

  task automatic idle();
    row_open = 0; row_close = 0; col_stb = 0; wr_en = 0; blk_sel = 0;
  endtask

  task automatic load_colour(logic [3:0] c);
    @(negedge clk); row_open = 1; blk_sel = 1; din = c;
    @(negedge clk); idle(); m_colour = c;
  endtask

  task automatic open_row(int r, logic keep, logic off, logic [3:0] d);
    @(negedge clk); row_open = 1; mask_keep = keep; mask_off = off;
    addr = ADDR_W'(r); din = d;
    @(negedge clk); idle();
    m_row = ROW_BITS'(r); m_off = off;
    if (!keep && !off) m_mask = d;
  endtask

  task automatic close_row();
    @(negedge clk); row_close = 1;
    @(negedge clk); idle();
  endtask

  task automatic blk_write(int c, logic [3:0] cm);
    @(negedge clk); col_stb = 1; wr_en = 1; blk_sel = 1; addr = ADDR_W'(c); din = cm;
    @(negedge clk); idle();
    for (int n = 0; n < 4; n++) if (cm[n]) begin
      int i = int'(m_row) * NCOL + ((c & ~3) | n);
      ref_mem[i] = (ref_mem[i] & ~eff()) | (m_colour & eff());
    end
  endtask

  task automatic wr_word(int c, logic [3:0] d);
    @(negedge clk); col_stb = 1; wr_en = 1; addr = ADDR_W'(c); din = d;
    @(negedge clk); idle();
    begin
      int i = int'(m_row) * NCOL + c;
      ref_mem[i] = (ref_mem[i] & ~eff()) | (d & eff());
    end
  endtask

  task automatic rd_check(string req, int c);
    @(negedge clk); col_stb = 1; wr_en = 0; addr = ADDR_W'(c);
    @(negedge clk); idle();
    check(req, {3'b0, rd_valid, rd_data}, {4'b0001, ref_mem[int'(m_row) * NCOL + c]});
    @(negedge clk);
    check({req, " valid drop"}, {7'b0, rd_valid}, 8'h00);
  endtask

  task automatic read_row(string req, int r);
    open_row(r, 1, 0, 4'h0);
    for (int c = 0; c < NCOL; c++) rd_check(req, c);
    close_row();
  endtask

  task automatic t_reset();
    check("R1 rd_valid", {7'b0, rd_valid}, 8'h00);
    // reset colour is 0, reset mask all ones: block write into row 0 group 0
    m_mask = 4'hF; m_colour = 4'h0; m_off = 0;
    for (int i = 0; i < NROW*NCOL; i++) ref_mem[i] = 4'h0;
    open_row(0, 1, 0, 4'h0);
    blk_write(0, 4'hF);
    for (int c = 0; c < 4; c++) rd_check("R1 reset colour/mask", c);
    close_row();
  endtask

  task automatic t_fill();
    load_colour(4'h0);
    for (int r = 0; r < NROW; r++) begin
      open_row(r, 0, 1, 4'h0);
      for (int g = 0; g < NCOL; g += 4) blk_write(g, 4'hF);
      close_row();
    end
    load_colour(4'hA);
    open_row(2, 0, 1, 4'h0);
    blk_write(9, 4'b1010);   // low bits 01 ignored: columns 9 and 11
    blk_write(22, 4'b0101);  // columns 20 and 22
    close_row();
    read_row("R7 block group/colmask", 2);
  endtask

  task automatic t_colour_page_closed();
    load_colour(4'h5);
    // a block write right after a colour load finds no open page
    @(negedge clk); col_stb = 1; wr_en = 1; blk_sel = 1; addr = 0; din = 4'hF;
    @(negedge clk); idle();
    @(negedge clk); col_stb = 1; wr_en = 0;
    @(negedge clk); idle();
    check("R2 no page after colour load", {7'b0, rd_valid}, 8'h00);
    open_row(3, 0, 1, 4'h0);
    blk_write(4, 4'hF);
    close_row();
    @(negedge clk); col_stb = 1; wr_en = 1; addr = 8; din = 4'hF;  // closed page
    @(negedge clk); idle();
    read_row("R2 R3 colour/row", 3);
  endtask

  task automatic t_masks();
    load_colour(4'hF);
    open_row(4, 0, 0, 4'b0011);          // load mask
    blk_write(0, 4'hF);
    close_row();
    read_row("R4 R8 loaded mask", 4);
    load_colour(4'h0);
    open_row(5, 1, 0, 4'hC);             // reuse 0011, din ignored
    blk_write(0, 4'b0110);
    wr_word(8, 4'h0);
    close_row();
    read_row("R5 R9 reuse mask", 5);
    load_colour(4'h9);
    open_row(6, 1, 1, 4'h0);             // bypass, both high
    mask_off = 0; mask_keep = 0;         // mode changes inside page
    blk_write(12, 4'hF);
    wr_word(16, 4'h6);
    close_row();
    read_row("R6 R11 bypass", 6);
    open_row(7, 1, 0, 4'h0);             // stored mask still 0011
    mask_off = 1;
    wr_word(1, 4'hF);
    close_row();
    read_row("R6 R11 mask persists", 7);
  endtask

  task automatic t_random();
    for (int p = 0; p < 24; p++) begin
      int r = $urandom_range(NROW-1);
      int k = $urandom_range(2);
      load_colour(4'($urandom));
      open_row(r, k == 1, k == 2, 4'($urandom));
      for (int j = 0; j < 6; j++) begin
        if ($urandom_range(3) == 0) wr_word($urandom_range(NCOL-1), 4'($urandom));
        else blk_write($urandom_range(NCOL-1), 4'($urandom));
      end
      close_row();
    end
    for (int r = 0; r < NROW; r++) read_row("R4 R5 R6 R7 random", r);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_colour_page_closed();
    t_masks();
    t_random();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule